// File: doc/BRIEF.md
# Network Controller Host Register Block

This block is the host-side register front end of a ring-buffer network controller. A single bus window is split into three regions by address bits [19:16]. Code 0xD reaches an external packet RAM, 0xE reaches a bank of paged byte registers, and 0xF reaches an external configuration ROM. Packet RAM and ROM are not stored here. The block routes the access to the external array and returns that array's read byte on the bus.

The register bank is paged. The page is set by the top two bits of the command register, and the command register itself is reachable from every page. On page 0 a read and a write to the same index reach different registers. On page 1 the same registers are seen for read and write: the station address bytes, the current receive page and the multicast filter bytes.

The block keeps the interrupt status and mask registers and drives an active-low interrupt line. It hands the receive ring pointers and the transmit byte count to the datapath. It raises a one-cycle transmit request and takes a one-cycle transmit-done pulse back.

Top module: `nic_host_regs`

## Requirements
- R1: With `bus_req` high, address bits [19:16] = 0xD raise `ram_req`, and also `ram_we` on a write. `ram_addr` equals address bits [13:0], so the address wraps within 16 KiB. A read returns `ram_rdata`. Any region code other than 0xD, 0xE or 0xF raises no strobe and reads as 0x00.
- R2: The register index is 15 XOR address bits [5:2]. Index 0 is the command register on every page. The page number is command bits [7:6].
- R3: After reset the command register reads 0x01 (bit 0 STP set) and the status register reads 0x80 (bit 7 RST set). `irq_n` is 1, `tx_start` is 0, and all ring pointers and `tx_count` are 0.
- R4: A command write with bit 1 (STA) set clears status bit 7. A command write that changes bit 2 (TXP) from 0 to 1 raises `tx_start` for exactly the one cycle after the write. A write while TXP is already 1 raises nothing.
- R5: A `tx_done` pulse clears command bit 2 and sets status bit 1 (PTX). It drives `irq_n` low only if mask bit 1 is set.
- R6: A page-0 write to index 7 clears every status bit written as 1 in bits [6:0]. Bit 7 is never cleared this way.
- R7: After such a write, status bit 0 (PRX) is set again if curr differs from bnry+1. Here bnry+1 is replaced by pstart when it is greater than or equal to pstop.
- R8: `irq_n` returns high only on a status write that leaves bits 0 and 1 clear while command bit 0 is clear. Otherwise it stays low.
- R9: The mask register (page-0 write index 15) keeps only bits [6:0]. Writing bit 7 has no effect on interrupt gating.
- R10: Page-0 reads return bnry at index 3, status at index 7 and 0x00 at every other nonzero index. Page-0 write indices 1, 2 and 3 set pstart, pstop and bnry.
- R11: Page-0 write index 5 sets the low byte of `tx_count` and index 6 sets its high byte. On page 1, indices 1 to 15 read back what was written to them, and index 7 is curr.
- R12: On pages 2 and 3, nonzero indices read 0x00 and writes to them change nothing.
- R13: A ROM access drives `rom_addr` with address bits [12:1]. An even address reads `rom_rdata` and an odd address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address in the window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| ram_req | output | 1 | Packet RAM access strobe |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | 14 | Packet RAM byte address |
| ram_wdata | output | 8 | Packet RAM write byte |
| ram_rdata | input | 8 | Packet RAM read byte |
| rom_addr | output | 12 | ROM byte address |
| rom_rdata | input | 8 | ROM read byte |
| tx_start | output | 1 | One-cycle transmit request |
| tx_done | input | 1 | One-cycle transmit-complete pulse |
| ring_start | output | 8 | First receive ring page |
| ring_stop | output | 8 | Receive ring end page (exclusive) |
| ring_bound | output | 8 | Boundary page last freed by host |
| ring_curr | output | 8 | Next page the receiver writes |
| tx_count | output | 16 | Transmit byte count |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench targets the PRX re-arm at the ring end, where bnry+1 reaches pstop and must fold back to pstart. A design that skipped the fold would leave PRX set with no pending packet.

It writes 0xFF to the status register right after reset. A design that cleared RST on that write would lose the power-up indication.

It completes a transmit while STP is set. A release that ignored STP would raise `irq_n` early.

It writes the command register twice with TXP set. A design triggering on level instead of edge would send the frame twice.

Page 2 and 3 accesses and the inverted index catch decoders that alias pages or use the address bits as they are.

// File: rtl/nic_host_pkg.sv
package nic_host_pkg;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_REG  = 2'd2,
    RGN_ROM  = 2'd3
  } region_e;

  localparam int CMD_STP = 0;
  localparam int CMD_STA = 1;
  localparam int CMD_TXP = 2;

  localparam int IS_PRX = 0;
  localparam int IS_PTX = 1;
  localparam int IS_RST = 7;

  localparam logic [3:0] IDX_CMD    = 4'd0;
  localparam logic [3:0] IDX_PSTART = 4'd1;
  localparam logic [3:0] IDX_PSTOP  = 4'd2;
  localparam logic [3:0] IDX_BOUND  = 4'd3;
  localparam logic [3:0] IDX_TCLO   = 4'd5;
  localparam logic [3:0] IDX_TCHI   = 4'd6;
  localparam logic [3:0] IDX_STATUS = 4'd7;
  localparam logic [3:0] IDX_MASK   = 4'd15;
  localparam logic [3:0] IDX_CURR   = 4'd7;

  function automatic logic [3:0] reg_index(input logic [3:0] abits);
    return 4'hF ^ abits;
  endfunction

  function automatic logic [7:0] ring_next(input logic [7:0] bnd,
                                           input logic [7:0] first,
                                           input logic [7:0] last);
    logic [7:0] n;
    n = bnd + 8'd1;
    return (n >= last) ? first : n;
  endfunction

endpackage

// File: rtl/nic_bus_decode.sv
module nic_bus_decode
  import nic_host_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int RAM_AW = 14,
  parameter int ROM_AW = 12,
  parameter logic [3:0] RAM_CODE = 4'hD,
  parameter logic [3:0] REG_CODE = 4'hE,
  parameter logic [3:0] ROM_CODE = 4'hF
) (
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output region_e           region,
  output logic [3:0]        reg_idx,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_odd
);
  localparam int CODE_LSB = ADDR_W - 4;

  logic [3:0] code;
  assign code = bus_addr[ADDR_W-1:CODE_LSB];

  always_comb begin
    if (!bus_req)              region = RGN_NONE;
    else if (code == RAM_CODE) region = RGN_RAM;
    else if (code == REG_CODE) region = RGN_REG;
    else if (code == ROM_CODE) region = RGN_ROM;
    else                       region = RGN_NONE;
  end

  assign reg_idx  = reg_index(bus_addr[5:2]);
  assign ram_req  = (region == RGN_RAM);
  assign ram_we   = ram_req && bus_we;
  assign ram_addr = bus_addr[RAM_AW-1:0];
  assign rom_addr = bus_addr[ROM_AW:1];
  assign rom_odd  = bus_addr[0];

endmodule

// File: rtl/nic_page_regs.sv
module nic_page_regs
  import nic_host_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [3:0] idx,
  input  logic [7:0] wdata,
  input  logic       tx_done,
  output logic [7:0] cmd_q,
  output logic [7:0] pstart_q,
  output logic [7:0] pstop_q,
  output logic [7:0] bound_q,
  output logic [7:0] curr_q,
  output logic [15:0] tcount_q,
  output logic [7:0] p1_rdata,
  output logic       tx_start,
  output logic       status_wr,
  output logic       mask_wr,
  output logic       sta_wr
);
  logic [1:0] page;
  logic       cmd_wr, p0_wr, p1_wr, txp_rise;
  logic [7:0] cmd_nxt;
  logic [7:0] p1_q [NREG];

  assign page     = cmd_q[7:6];
  assign cmd_wr   = reg_wr && (idx == IDX_CMD);
  assign p0_wr    = reg_wr && (idx != IDX_CMD) && (page == 2'd0);
  assign p1_wr    = reg_wr && (idx != IDX_CMD) && (page == 2'd1);
  assign txp_rise = cmd_wr && wdata[CMD_TXP] && !cmd_q[CMD_TXP];
  assign status_wr = p0_wr && (idx == IDX_STATUS);
  assign mask_wr   = p0_wr && (idx == IDX_MASK);
  assign sta_wr    = cmd_wr && wdata[CMD_STA];

  always_comb begin
    cmd_nxt = cmd_q;
    if (cmd_wr) cmd_nxt = wdata;
    if (tx_done) cmd_nxt[CMD_TXP] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= 8'h01;
      tx_start <= 1'b0;
      pstart_q <= '0;
      pstop_q  <= '0;
      bound_q  <= '0;
      tcount_q <= '0;
    end else begin
      cmd_q    <= cmd_nxt;
      tx_start <= txp_rise;
      if (p0_wr && idx == IDX_PSTART) pstart_q <= wdata;
      if (p0_wr && idx == IDX_PSTOP)  pstop_q  <= wdata;
      if (p0_wr && idx == IDX_BOUND)  bound_q  <= wdata;
      if (p0_wr && idx == IDX_TCLO)   tcount_q[7:0]  <= wdata;
      if (p0_wr && idx == IDX_TCHI)   tcount_q[15:8] <= wdata;
    end
  end

  // Page-1 bytes: station address, current page, multicast filter.
  assign p1_q[0] = 8'h00;
  for (genvar i = 1; i < NREG; i++) begin : g_p1
    always_ff @(posedge clk) begin
      if (!rst_n)                      p1_q[i] <= '0;
      else if (p1_wr && idx == 4'(i))  p1_q[i] <= wdata;
    end
  end

  assign curr_q   = p1_q[IDX_CURR];
  assign p1_rdata = p1_q[idx];

  AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);                                    // R4
  AST_TXDONE_CLEARS_TXP: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !cmd_q[CMD_TXP]);                               // R5
  AST_HI_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && page[1] && idx != IDX_CMD) |=>
      ($stable(bound_q) && $stable(pstart_q) && $stable(curr_q))); // R12

endmodule

// File: rtl/nic_int_ctl.sv
module nic_int_ctl
  import nic_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       status_wr,
  input  logic       mask_wr,
  input  logic       sta_wr,
  input  logic [7:0] wdata,
  input  logic       tx_done,
  input  logic       stopped,
  input  logic [7:0] curr,
  input  logic [7:0] bound,
  input  logic [7:0] pstart,
  input  logic [7:0] pstop,
  output logic [7:0] status_q,
  output logic       irq_n
);
  logic [6:0] mask_q;
  logic [7:0] status_nxt;
  logic       irq_n_nxt;
  logic       rx_pending;

  assign rx_pending = (curr != ring_next(bound, pstart, pstop));

  always_comb begin
    status_nxt = status_q;
    if (sta_wr) status_nxt[IS_RST] = 1'b0;
    if (status_wr) begin
      status_nxt = status_nxt & ~{1'b0, wdata[6:0]};
      if (rx_pending) status_nxt[IS_PRX] = 1'b1;
    end
    if (tx_done) status_nxt[IS_PTX] = 1'b1;
  end

  always_comb begin
    irq_n_nxt = irq_n;
    if (status_wr && status_nxt[IS_PTX:IS_PRX] == 2'b00 && !stopped)
      irq_n_nxt = 1'b1;
    if (tx_done && mask_q[IS_PTX]) irq_n_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= 8'h80;
      mask_q   <= '0;
      irq_n    <= 1'b1;
    end else begin
      status_q <= status_nxt;
      irq_n    <= irq_n_nxt;
      if (mask_wr) mask_q <= wdata[6:0];
    end
  end

  AST_RST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_wr |=> status_q[IS_RST] == $past(status_q[IS_RST]));   // R6
  AST_PRX_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (status_wr && rx_pending) |=> status_q[IS_PRX]);              // R7
  AST_IRQ_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !status_wr) |=> !irq_n);                          // R8
  AST_PTX_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> status_q[IS_PTX]);                                // R5

endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nic_host_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int RAM_AW = 14,
  parameter int ROM_AW = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              ram_req,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_rdata,
  output logic              tx_start,
  input  logic              tx_done,
  output logic [7:0]        ring_start,
  output logic [7:0]        ring_stop,
  output logic [7:0]        ring_bound,
  output logic [7:0]        ring_curr,
  output logic [15:0]       tx_count,
  output logic              irq_n
);
  localparam int NREG = 16;

  region_e    region;
  logic [3:0] reg_idx;
  logic       rom_odd, reg_wr;
  logic [7:0] cmd_q, status_q, p1_rdata, reg_rdata;
  logic       status_wr, mask_wr, sta_wr;
  logic [1:0] page;

  nic_bus_decode #(
    .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .ROM_AW(ROM_AW)
  ) u_dec (
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .region(region), .reg_idx(reg_idx), .ram_req(ram_req), .ram_we(ram_we),
    .ram_addr(ram_addr), .rom_addr(rom_addr), .rom_odd(rom_odd)
  );

  assign reg_wr    = (region == RGN_REG) && bus_we;
  assign ram_wdata = bus_wdata;
  assign page      = cmd_q[7:6];

  nic_page_regs #(.NREG(NREG)) u_pages (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .idx(reg_idx),
    .wdata(bus_wdata), .tx_done(tx_done), .cmd_q(cmd_q),
    .pstart_q(ring_start), .pstop_q(ring_stop), .bound_q(ring_bound),
    .curr_q(ring_curr), .tcount_q(tx_count), .p1_rdata(p1_rdata),
    .tx_start(tx_start), .status_wr(status_wr), .mask_wr(mask_wr),
    .sta_wr(sta_wr)
  );

  nic_int_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .status_wr(status_wr), .mask_wr(mask_wr),
    .sta_wr(sta_wr), .wdata(bus_wdata), .tx_done(tx_done),
    .stopped(cmd_q[CMD_STP]), .curr(ring_curr), .bound(ring_bound),
    .pstart(ring_start), .pstop(ring_stop), .status_q(status_q),
    .irq_n(irq_n)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_idx == IDX_CMD) reg_rdata = cmd_q;
    else if (page == 2'd0) begin
      if (reg_idx == IDX_BOUND)       reg_rdata = ring_bound;
      else if (reg_idx == IDX_STATUS) reg_rdata = status_q;
    end else if (page == 2'd1) reg_rdata = p1_rdata;
  end

  always_comb begin
    case (region)
      RGN_RAM: bus_rdata = ram_rdata;
      RGN_REG: bus_rdata = reg_rdata;
      RGN_ROM: bus_rdata = rom_odd ? '0 : rom_rdata;
      default: bus_rdata = '0;
    endcase
  end

  AST_HI_PAGE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_REG && !bus_we && page[1] && reg_idx != IDX_CMD)
      |-> bus_rdata == '0);                                     // R12
  AST_ROM_ODD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_ROM && bus_addr[0]) |-> bus_rdata == '0);     // R13
  AST_STRAY_REGION_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RGN_NONE) |-> (!ram_req && bus_rdata == '0));     // R1

endmodule

// File: tb/nic_host_regs_bench.sv
module nic_host_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [19:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, ram_rdata = 8'h00, rom_rdata = 8'h00;
  logic        tx_done = 0;
  logic [7:0]  bus_rdata, ram_wdata, ring_start, ring_stop, ring_bound, ring_curr;
  logic        ram_req, ram_we, tx_start, irq_n;
  logic [13:0] ram_addr;
  logic [11:0] rom_addr;
  logic [15:0] tx_count;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_cmd, m_stat, m_mask, m_ps, m_pe, m_bn;
  logic [7:0] m_p1 [16];
  logic [15:0] m_tc;
  logic m_irq_n;

  always #4 clk = ~clk;

  nic_host_regs u_nic_host_regs (.*);

  function automatic logic [19:0] reg_addr(input int idx);
    return {4'hE, 10'd0, 4'(15 - idx), 2'b00};
  endfunction

  function automatic logic [7:0] wrap_after(input logic [7:0] b, input logic [7:0] s,
                                            input logic [7:0] e);
    int t;
    t = (int'(b) + 1) % 256;
    if (t >= int'(e)) t = int'(s);
    return 8'(t);
  endfunction

  function automatic logic [7:0] exp_reg(input int idx);
    int pg;
    pg = m_cmd[7:6];
    if (idx == 0) return m_cmd;
    if (pg == 0) return (idx == 3) ? m_bn : (idx == 7) ? m_stat : 8'h00;
    if (pg == 1) return m_p1[idx];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [19:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] d);
    int pg;
    pg = m_cmd[7:6];
    if (idx == 0) begin
      if (d[1]) m_stat[7] = 1'b0;
      m_cmd = d;
    end else if (pg == 0) begin
      case (idx)
        1: m_ps = d;
        2: m_pe = d;
        3: m_bn = d;
        5: m_tc[7:0] = d;
        6: m_tc[15:8] = d;
        7: begin
          m_stat = m_stat & ~{1'b0, d[6:0]};
          if (m_p1[7] != wrap_after(m_bn, m_ps, m_pe)) m_stat[0] = 1'b1;
          if (m_stat[1:0] == 2'b00 && !m_cmd[0]) m_irq_n = 1'b1;
        end
        15: m_mask = {1'b0, d[6:0]};
        default: ;
      endcase
    end else if (pg == 1) m_p1[idx] = d;
    bus_write(reg_addr(idx), d);
  endtask

  task automatic rd_check(input string req, input int idx);
    logic [7:0] v;
    bus_read(reg_addr(idx), v);
    check(req, v, exp_reg(idx));
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    m_cmd[2] = 1'b0; m_stat[1] = 1'b1;
    if (m_mask[1]) m_irq_n = 1'b0;
  endtask

  task automatic set_page(input int pg);
    wr_reg(0, {2'(pg), 4'b0000, m_cmd[1], 1'b0});
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_cmd = 8'h01; m_stat = 8'h80; m_mask = 0; m_ps = 0; m_pe = 0; m_bn = 0;
    m_tc = 0; m_irq_n = 1;
    for (int i = 0; i < 16; i++) m_p1[i] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R3 reset state
    rd_check("R3 cmd", 0);
    rd_check("R3 status", 7);
    check("R3 irq_n", irq_n, 1'b1);
    check("R3 tx_start", tx_start, 1'b0);
    check("R3 pointers", {ring_start, ring_stop, ring_bound, ring_curr, tx_count}, 48'h0);

    // R6 RST survives a write of all ones
    wr_reg(7, 8'hFF);
    rd_check("R6 rst sticky", 7);

    // R2 raw address bits [5:2]=1111 reach the command register
    bus_read(20'hE003C, v);
    check("R2 inverted index", v, 8'h01);

    // R4 STA clears RST
    wr_reg(0, 8'h02);
    rd_check("R4 sta clears rst", 7);

    // R10 ring setup, R11 tx count
    wr_reg(1, 8'h10); wr_reg(2, 8'h20); wr_reg(3, 8'h10);
    wr_reg(5, 8'h3C); wr_reg(6, 8'h05);
    check("R11 tx_count", tx_count, 16'h053C);
    check("R10 ring outputs", {ring_start, ring_stop, ring_bound}, 24'h102010);
    rd_check("R10 pstart reads zero", 1);
    rd_check("R10 bound", 3);
    set_page(1);
    wr_reg(7, 8'h11);
    check("R11 curr out", ring_curr, 8'h11);
    rd_check("R11 curr", 7);
    set_page(0);

    // R9 mask, bit 7 ignored
    wr_reg(15, 8'h82);

    // R4 TXP edge
    wr_reg(0, 8'h06);
    check("R4 tx_start pulse", tx_start, 1'b1);
    @(negedge clk);
    check("R4 tx_start one cycle", tx_start, 1'b0);
    wr_reg(0, 8'h06);
    check("R4 no retrigger", tx_start, 1'b0);

    // R5 completion
    pulse_done();
    rd_check("R5 txp cleared", 0);
    rd_check("R5 ptx set", 7);
    check("R5 irq low", irq_n, m_irq_n);

    // R8 release
    wr_reg(7, 8'h02);
    rd_check("R6 ptx cleared", 7);
    check("R8 irq released", irq_n, 1'b1);

    // R7 rearm: curr away from bnry+1
    set_page(1); wr_reg(7, 8'h15); set_page(0);
    pulse_done();
    wr_reg(7, 8'h03);
    rd_check("R7 prx rearmed", 7);
    check("R8 irq kept while prx", irq_n, 1'b0);

    // R7 wrap: bnry=0x1F, next is pstart=0x10
    wr_reg(3, 8'h1F);
    set_page(1); wr_reg(7, 8'h10); set_page(0);
    wr_reg(7, 8'h01);
    rd_check("R7 wrap no rearm", 7);
    check("R8 irq released at wrap", irq_n, 1'b1);

    // R8 STP holds the line
    wr_reg(0, 8'h01);
    pulse_done();
    wr_reg(7, 8'h7F);
    check("R8 stp holds irq", irq_n, 1'b0);
    wr_reg(0, 8'h02);
    wr_reg(7, 8'h00);
    check("R8 release after start", irq_n, 1'b1);

    // R5/R9 masked completion
    wr_reg(15, 8'h80);
    pulse_done();
    check("R9 mask bit7 no effect", irq_n, 1'b1);
    wr_reg(7, 8'h02);

    // R12 high pages
    set_page(2);
    wr_reg(3, 8'h55);
    rd_check("R12 page2 read", 3);
    set_page(3);
    rd_check("R12 page3 read", 7);
    set_page(0);
    rd_check("R12 bound unchanged", 3);

    // R1 RAM window and stray region
    ram_rdata = 8'hA7;
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = 20'hDC005;
    #1 check("R1 ram addr wrap", {ram_req, ram_we, ram_addr}, {1'b1, 1'b0, 14'h0005});
    check("R1 ram data", bus_rdata, 8'hA7);
    bus_we = 1; bus_wdata = 8'h3D;
    #1 check("R1 ram write", {ram_we, ram_wdata}, {1'b1, 8'h3D});
    bus_we = 0; bus_addr = 20'hA0004;
    #1 check("R1 stray region", {ram_req, bus_rdata}, 9'h000);
    @(negedge clk); bus_req = 0;

    // R13 ROM
    rom_rdata = 8'h5E;
    bus_read(20'hF0246, v);
    check("R13 rom even", {rom_addr, v}, {12'h123, 8'h5E});
    bus_read(20'hF0247, v);
    check("R13 rom odd", v, 8'h00);

    // Random phase across pages, ring and status
    for (int it = 0; it < 400; it++) begin
      int sel, idx;
      sel = $urandom_range(0, 9);
      idx = $urandom_range(1, 15);
      if (sel == 0) set_page($urandom_range(0, 3));
      else if (sel <= 4) wr_reg(idx, 8'($urandom));
      else if (sel == 5) pulse_done();
      else if (sel == 6) wr_reg(15, 8'($urandom));
      else rd_check("R11 random readback", idx);
      check("R8 random irq", irq_n, m_irq_n);
      check("R10 random ring", {ring_start, ring_stop, ring_bound, ring_curr, tx_count},
            {m_ps, m_pe, m_bn, m_p1[7], m_tc});
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule